// File: doc/BRIEF.md
# Low-Power Sleep Mode Controller

This block picks the low-power state a processor core drops into when it executes its sleep instruction, and brings the core back out. A one-cycle sleep strobe from the core, sampled while the core is running, selects one of three depths from the standby bits of two clock-control register values. The shallowest depth stops only the core. The middle depth also stops the DMA engine. The deepest depth first asks the timer and serial units to catch up on their pending time, and then halts them.

While the core sleeps, timed events are still granted service without waking it. A pending interrupt returns the core to running from any depth, marked by a one-cycle wake pulse. Reset forces the running state at any time.

Top module: `sleep_mode_ctrl`

## Requirements
- R1: A synchronous active-low reset sets pwr_state to 0 (running) and drives every other output low, from any state and with any inputs.
- R2: A sleep_req sampled while running, with bit 7 of stby_ctl_a set, makes pwr_state 3 (standby) after the next clock edge, whatever stby_ctl_b holds.
- R3: A sleep_req sampled while running, with bit 7 of stby_ctl_a clear and bit 7 of stby_ctl_b set, makes pwr_state 2 (deep sleep).
- R4: A sleep_req sampled while running, with bit 7 of both registers clear, makes pwr_state 1 (sleep). Bits 0 to 6 of both registers have no effect on the chosen state.
- R5: In the first cycle of standby, catchup_ts is high and halt_timer and halt_serial are low. From the second standby cycle on, halt_timer and halt_serial are high and catchup_ts is low.
- R6: halt_dma is high exactly while pwr_state is 2. In sleep state 1, no halt output is high.
- R7: irq_pend sampled in any sleep state returns pwr_state to 0 after the next edge. wake_pulse is high for exactly that one cycle, and all halt outputs are low in it.
- R8: evt_service equals evt_pend whenever pwr_state is not 0 and is low while running. A pending event alone does not change the state.
- R9: A sleep_req made while already asleep is ignored: the state and the halt outputs are unchanged.
- R10: irq_pend while running produces no wake pulse. Reset from a sleep state produces no wake pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | Sleep instruction strobe from the core |
| stby_ctl_a | input | 8 | First clock-control register value; bit 7 selects standby |
| stby_ctl_b | input | 8 | Second clock-control register value; bit 7 selects deep sleep |
| irq_pend | input | 1 | An interrupt is pending |
| evt_pend | input | 1 | A timed event is pending |
| pwr_state | output | 2 | 0 running, 1 sleep, 2 deep sleep, 3 standby |
| catchup_ts | output | 1 | Bring timer and serial up to date (first standby cycle) |
| halt_timer | output | 1 | Timer halted |
| halt_serial | output | 1 | Serial unit halted |
| halt_dma | output | 1 | DMA engine halted |
| evt_service | output | 1 | Timed event serviced while asleep |
| wake_pulse | output | 1 | One-cycle pulse on return to running |

## Verification
The hardest case to reach from the ports is an interrupt that arrives in the single catch-up cycle of standby. The state must then leave standby before the timer and serial halts are ever raised, while the wake pulse still fires. Directed sequences enter standby and raise irq_pend in the very next cycle. Random stimulus then mixes sleep strobes, interrupts, events and resets, with irq_pend kept sparse so that long sleeps and their transitions both occur. Every cycle is compared against a reference model in the bench.

// File: rtl/sleep_mode_pkg.sv
// Package: shared power-state encoding for the sleep mode controller.
package sleep_mode_pkg;
    typedef enum logic [1:0] {
        PS_RUN   = 2'd0,
        PS_LIGHT = 2'd1,
        PS_DEEP  = 2'd2,
        PS_STBY  = 2'd3
    } pwr_state_e;
endpackage

// File: rtl/sleep_depth_sel.sv
// Module: sleep_depth_sel
// Picks the sleep depth from the standby bits of the two control registers.
// The first register's bit has priority over the second's.
// Assumes both registers are stable while a sleep request is sampled.
module sleep_depth_sel
    import sleep_mode_pkg::*;
#(
    parameter int CTL_W    = 8,
    parameter int STBY_BIT = 7
) (
    input  logic [CTL_W-1:0] ctl_a,
    input  logic [CTL_W-1:0] ctl_b,
    output pwr_state_e       depth
);
    // Priority decode of the two standby bits
    always_comb begin
        if (ctl_a[STBY_BIT])      depth = PS_STBY;
        else if (ctl_b[STBY_BIT]) depth = PS_DEEP;
        else                      depth = PS_LIGHT;
    end
endmodule

// File: rtl/sleep_state_fsm.sv
// Module: sleep_state_fsm
// Holds the power state. A sleep request is taken only while running.
// A pending interrupt wakes the core from any sleep depth.
// The wake pulse is registered so that it lines up with the first running cycle.
module sleep_state_fsm
    import sleep_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       irq_pend,
    input  pwr_state_e depth,
    output pwr_state_e state,
    output logic       wake
);
    pwr_state_e state_nxt;
    logic       wake_nxt;

    // Next-state decision: enter the chosen depth, or wake on interrupt
    always_comb begin
        state_nxt = state;
        wake_nxt  = 1'b0;
        if (state == PS_RUN) begin
            if (sleep_req) state_nxt = depth;
        end else if (irq_pend) begin
            state_nxt = PS_RUN;
            wake_nxt  = 1'b1;
        end
    end

    // State and wake pulse registers, with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PS_RUN;
            wake  <= 1'b0;
        end else begin
            state <= state_nxt;
            wake  <= wake_nxt;
        end
    end
endmodule

// File: rtl/sleep_halt_ctrl.sv
// Module: sleep_halt_ctrl
// Derives the peripheral halt enables from the power state.
// Standby spends one catch-up cycle before the timer and serial halts rise.
// Deep sleep halts only the DMA engine.
// Assumes the state comes from sleep_state_fsm, clocked on the same edge.
module sleep_halt_ctrl
    import sleep_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  pwr_state_e state,
    input  logic       irq_pend,
    output logic       catchup,
    output logic       halt_ts,
    output logic       halt_dma
);
    // Timer/serial halt rises after one standby cycle and drops on wake
    always_ff @(posedge clk) begin
        if (!rst_n) halt_ts <= 1'b0;
        else        halt_ts <= (state == PS_STBY) && !irq_pend;
    end

    // Catch-up strobe in the first standby cycle; DMA halt follows deep sleep
    always_comb begin
        catchup  = (state == PS_STBY) && !halt_ts;
        halt_dma = (state == PS_DEEP);
    end
endmodule

// File: rtl/sleep_mode_ctrl.sv
// Module: sleep_mode_ctrl (top)
// Low-power sleep mode controller: picks the sleep depth, tracks the state,
// drives the peripheral halts, grants timed events while asleep and pulses on wake.
// Assumes sleep_req is a single-cycle strobe from the core.
module sleep_mode_ctrl
    import sleep_mode_pkg::*;
#(
    parameter int CTL_W    = 8,
    parameter int STBY_BIT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic [CTL_W-1:0] stby_ctl_a,
    input  logic [CTL_W-1:0] stby_ctl_b,
    input  logic             irq_pend,
    input  logic             evt_pend,
    output logic [1:0]       pwr_state,
    output logic             catchup_ts,
    output logic             halt_timer,
    output logic             halt_serial,
    output logic             halt_dma,
    output logic             evt_service,
    output logic             wake_pulse
);
    pwr_state_e depth;
    pwr_state_e state;
    logic       halt_ts;

    sleep_depth_sel #(.CTL_W(CTL_W), .STBY_BIT(STBY_BIT)) u_depth (
        .ctl_a (stby_ctl_a),
        .ctl_b (stby_ctl_b),
        .depth (depth)
    );

    sleep_state_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .irq_pend  (irq_pend),
        .depth     (depth),
        .state     (state),
        .wake      (wake_pulse)
    );

    sleep_halt_ctrl u_halt (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .irq_pend (irq_pend),
        .catchup  (catchup_ts),
        .halt_ts  (halt_ts),
        .halt_dma (halt_dma)
    );

    // Output mapping; timed events are granted only while asleep
    always_comb begin
        pwr_state   = state;
        halt_timer  = halt_ts;
        halt_serial = halt_ts;
        evt_service = evt_pend && (state != PS_RUN);
    end
endmodule

// File: rtl/sleep_mode_ctrl_chk.sv
// Module: sleep_mode_ctrl_chk
// Property checker for sleep_mode_ctrl, attached through bind.
module sleep_mode_ctrl_chk #(
    parameter int CTL_W    = 8,
    parameter int STBY_BIT = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep_req,
    input logic [CTL_W-1:0] stby_ctl_a,
    input logic [CTL_W-1:0] stby_ctl_b,
    input logic             irq_pend,
    input logic             evt_pend,
    input logic [1:0]       pwr_state,
    input logic             catchup_ts,
    input logic             halt_timer,
    input logic             halt_serial,
    input logic             halt_dma,
    input logic             evt_service,
    input logic             wake_pulse
);
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (pwr_state == 2'd0 && !wake_pulse && !halt_timer && !halt_serial));

    a_r2_enter_standby: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && pwr_state == 2'd0 && stby_ctl_a[STBY_BIT]) |=> pwr_state == 2'd3);

    a_r5_catchup_then_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (catchup_ts && !irq_pend) |=> (halt_timer && halt_serial && !catchup_ts));

    a_r5_halt_in_standby: assert property (@(posedge clk) disable iff (!rst_n)
        halt_timer |-> (pwr_state == 2'd3 && halt_serial));

    a_r6_dma_only_deep: assert property (@(posedge clk) disable iff (!rst_n)
        halt_dma |-> pwr_state == 2'd2);

    a_r7_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    a_r7_wake_from_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != 2'd0 && irq_pend) |=> (wake_pulse && pwr_state == 2'd0));

    a_r9_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != 2'd0 && !irq_pend) |=> $stable(pwr_state));

    a_r10_no_wake_running: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0) |=> !wake_pulse);
endmodule

bind sleep_mode_ctrl sleep_mode_ctrl_chk #(.CTL_W(CTL_W), .STBY_BIT(STBY_BIT)) u_chk (.*);

// File: tb/sleep_mode_ctrl_bench.sv
module sleep_mode_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0;
    logic [7:0] stby_ctl_a = 8'h00;
    logic [7:0] stby_ctl_b = 8'h00;
    logic       irq_pend = 1'b0;
    logic       evt_pend = 1'b0;
    logic [1:0] pwr_state;
    logic       catchup_ts, halt_timer, halt_serial, halt_dma, evt_service, wake_pulse;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model state
    logic [1:0] m_st   = 2'd0;
    logic       m_halt = 1'b0;
    logic       m_wake = 1'b0;

    always #10 clk = ~clk;

    sleep_mode_ctrl u_sleep_mode_ctrl (.*);

    function automatic logic [1:0] exp_depth(input logic [7:0] a, input logic [7:0] b);
        if (a[7])      return 2'd3;
        else if (b[7]) return 2'd2;
        else           return 2'd1;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Drive one cycle: apply inputs, compare to model, clock, update model
    task automatic step(input logic rst, input logic slp, input logic [7:0] a,
                        input logic [7:0] b, input logic irq, input logic evt);
        rst_n = rst; sleep_req = slp; stby_ctl_a = a; stby_ctl_b = b;
        irq_pend = irq; evt_pend = evt;
        #1;
        chk("MODEL", "pwr_state", pwr_state, m_st);
        chk("MODEL", "catchup_ts", catchup_ts, (m_st == 2'd3) && !m_halt);
        chk("MODEL", "halt_timer", halt_timer, m_halt);
        chk("MODEL", "halt_serial", halt_serial, m_halt);
        chk("MODEL", "halt_dma", halt_dma, m_st == 2'd2);
        chk("MODEL", "evt_service", evt_service, evt && (m_st != 2'd0));
        chk("MODEL", "wake_pulse", wake_pulse, m_wake);
        @(posedge clk);
        if (!rst) begin
            m_st = 2'd0; m_halt = 1'b0; m_wake = 1'b0;
        end else begin
            m_halt = (m_st == 2'd3) && !irq;
            m_wake = (m_st != 2'd0) && irq;
            if (m_st == 2'd0) m_st = slp ? exp_depth(a, b) : 2'd0;
            else if (irq)     m_st = 2'd0;
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(1'b0, 1'b1, 8'hFF, 8'hFF, 1'b1, 1'b1);
        step(1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
        chk("R1", "reset state", pwr_state, 0);
        chk("R1", "reset wake", wake_pulse, 0);

        // R2: standby wins over the second register
        step(1'b1, 1'b1, 8'h80, 8'h80, 1'b0, 1'b0);
        chk("R2", "standby entry", pwr_state, 3);
        chk("R5", "catchup first cycle", catchup_ts, 1);
        chk("R5", "no halt first cycle", halt_timer, 0);
        step(1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1);
        chk("R5", "halt timer later", halt_timer, 1);
        chk("R5", "halt serial later", halt_serial, 1);
        chk("R5", "catchup ends", catchup_ts, 0);
        // R9: sleep request while asleep is ignored
        step(1'b1, 1'b1, 8'h00, 8'h80, 1'b0, 1'b0);
        chk("R9", "state held", pwr_state, 3);
        chk("R9", "halt held", halt_timer, 1);
        step(1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
        chk("R7", "wake state", pwr_state, 0);
        chk("R7", "wake pulse", wake_pulse, 1);
        chk("R7", "halts drop", halt_timer, 0);
        step(1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
        chk("R7", "pulse single", wake_pulse, 0);
        chk("R10", "irq while running", wake_pulse, 0);

        // R3: deep sleep
        step(1'b1, 1'b1, 8'h7F, 8'h80, 1'b0, 1'b0);
        chk("R3", "deep entry", pwr_state, 2);
        chk("R6", "dma halted", halt_dma, 1);
        chk("R6", "timer running", halt_timer, 0);
        step(1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1);
        chk("R8", "event serviced", evt_service, 1);
        chk("R8", "event no wake", pwr_state, 2);
        step(1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
        chk("R6", "dma released", halt_dma, 0);

        // R4: light sleep, low bits ignored
        step(1'b1, 1'b1, 8'h7F, 8'h7F, 1'b0, 1'b0);
        chk("R4", "light entry", pwr_state, 1);
        chk("R6", "no halts light", halt_dma | halt_timer, 0);
        step(1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
        chk("R10", "reset no pulse", wake_pulse, 0);
        chk("R1", "reset from sleep", pwr_state, 0);
        step(1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1);
        chk("R8", "no service running", evt_service, 0);

        // Interrupt during the standby catch-up cycle
        step(1'b1, 1'b1, 8'h80, 8'h00, 1'b0, 1'b0);
        step(1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
        chk("R7", "wake from catchup", pwr_state, 0);
        chk("R5", "halt never raised", halt_timer, 0);
        idle(2);

        // Constrained random against the model
        begin
            int s;
            s = $urandom(32'h5EED);
        end
        for (int i = 0; i < 4000; i++) begin
            logic r, sl, iq, ev;
            r  = ($urandom_range(0, 99) != 0);
            sl = ($urandom_range(0, 3) == 0);
            iq = ($urandom_range(0, 9) == 0);
            ev = ($urandom_range(0, 2) == 0);
            step(r, sl, 8'($urandom), 8'($urandom), iq, ev);
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule